// File: doc/BRIEF.md
# Port-to-LSU interface adapter

This block sits between a load/store port, as seen by a computation unit, and a pipelined load/store unit that has an execute stage and a memory stage. A request on the port carries a load or store bit, a byte length, a 48-bit address with a valid flag, and 64-bit store data. The adapter registers this request and turns it into the unit's request signals: a 16-byte line address, a 16-lane byte-enable mask, load and store strobes, a request valid and the store data. Going back the other way, it turns the unit's busy, load data and error flags into the port's busy, address-exception and load-data-with-valid outputs.

The byte mask is built from the 4-bit length and the low four address bits. One bit is set for each byte the access covers, and any bytes that would fall past the end of the 16-byte line are dropped. All outputs are registered, so a request sampled on one clock edge appears at the unit after that edge. A load counts as complete when the unit's execute-stage busy falls while that load is still pending. An abort input withdraws a request that is in flight.

Top module: `port_lsu_adapter`

## Requirements
- R1: One clock edge after a request is sampled, lsu_addr_o equals addr_i[47:4].
- R2: One clock edge after sampling, lsu_mask_o bit i is 1 exactly when ofs <= i <= ofs+len-1, where ofs = addr_i[3:0] and len = len_i. A length of 0 gives an all-zero mask, and lanes above 15 are discarded.
- R3: lsu_ld_o and lsu_st_o are registered copies of req_ld_i and req_st_i. When both requests are high in the same cycle, neither strobe is raised, so the two strobes are never high together.
- R4: lsu_valid_o is the registered value of addr_vld_i AND NOT lsu_stall_i AND exactly one request bit high. A stall therefore masks valid but leaves the strobes as they are.
- R5: lsu_st_data_o is the registered copy of st_data_i.
- R6: addr_exc_o is the registered OR of lsu_ld_err_i and lsu_st_err_i.
- R7: busy_o is the registered copy of lsu_busy_i.
- R8: After a load has been issued (lsu_ld_o and lsu_valid_o high), the first clock edge at which lsu_busy_i is seen low, having been high at the edge before, raises ld_ok_o for exactly one cycle and captures lsu_ld_data_i into ld_data_o. A fall of busy with no load pending produces no pulse. ld_data_o holds its value between pulses.
- R9: abort_i sampled high clears lsu_ld_o, lsu_st_o, lsu_valid_o and ld_ok_o on that edge and drops any pending load. A later fall of busy then gives no ld_ok_o pulse.
- R10: When a pending load completes on the same edge that a new load is issued, ld_ok_o pulses for the old load and the new load stays pending, so it gets its own pulse at the next fall of busy.
- R11: After synchronous reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Withdraw the current request and any pending load |
| req_ld_i | input | 1 | Load request |
| req_st_i | input | 1 | Store request |
| len_i | input | 4 | Access length in bytes |
| addr_i | input | 48 | Byte address |
| addr_vld_i | input | 1 | Address valid |
| st_data_i | input | 64 | Store data |
| busy_o | output | 1 | Unit execute stage busy (registered) |
| addr_exc_o | output | 1 | Load or store error reported by the unit |
| ld_data_o | output | 64 | Captured load data |
| ld_ok_o | output | 1 | One-cycle pulse: ld_data_o is valid |
| lsu_addr_o | output | 44 | Line address to the unit |
| lsu_mask_o | output | 16 | Byte-lane enables to the unit |
| lsu_ld_o | output | 1 | Load strobe to the unit |
| lsu_st_o | output | 1 | Store strobe to the unit |
| lsu_st_data_o | output | 64 | Store data to the unit |
| lsu_valid_o | output | 1 | Request valid to the unit |
| lsu_stall_i | input | 1 | Unit stalls the execute stage |
| lsu_busy_i | input | 1 | Unit execute stage busy |
| lsu_ld_data_i | input | 64 | Load data from the memory stage |
| lsu_ld_err_i | input | 1 | Load error |
| lsu_st_err_i | input | 1 | Store error |

## Verification
Two functions can act on the same clock edge: completion of a pending load, which is the fall of busy, and issue of the next load. Both update the pending-load flag. The bench provokes this by lowering busy with fresh load data in the same cycle that it raises a new load request. It then expects a ld_ok_o pulse carrying the first data, and a second pulse carrying different data at the next fall of busy, which shows that the new load was not lost when the old one was retired.

// File: rtl/plm_pkg.sv
package plm_pkg;
  localparam int ADDR_W_DEF = 48;
  localparam int DATA_W_DEF = 64;
  localparam int LANES_DEF  = 16;
  localparam int LEN_W_DEF  = 4;

  typedef struct packed {
    logic ld;
    logic st;
    logic vld;
  } plm_strobe_t;
endpackage

// File: rtl/plm_mask_expand.sv
module plm_mask_expand #(
  parameter int LANES = 16,
  parameter int LEN_W = 4,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LANES-1:0] mask_o
);
  // each lane decides independently whether it lies inside the access window
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask_o[i] = (i >= int'(ofs_i)) && ((i - int'(ofs_i)) < int'(len_i));
  end
endmodule

// File: rtl/plm_issue.sv
module plm_issue
  import plm_pkg::*;
#(
  parameter int LINE_W = 44,
  parameter int LANES  = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_i,
  input  logic              req_ld_i,
  input  logic              req_st_i,
  input  logic              addr_vld_i,
  input  logic              stall_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic [LINE_W-1:0] line_o,
  output logic [LANES-1:0]  mask_o,
  output logic [DATA_W-1:0] st_data_o,
  output logic              ld_o,
  output logic              st_o,
  output logic              vld_o,
  output logic              ld_issue_n_o
);
  plm_strobe_t strb_n, strb_q;
  logic        single;

  always_comb begin
    single     = req_ld_i ^ req_st_i;
    strb_n.ld  = req_ld_i & ~req_st_i;
    strb_n.st  = req_st_i & ~req_ld_i;
    strb_n.vld = addr_vld_i & ~stall_i & single;
    if (abort_i) strb_n = '0;
  end

  assign ld_issue_n_o = strb_n.ld & strb_n.vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q    <= '0;
      line_o    <= '0;
      mask_o    <= '0;
      st_data_o <= '0;
    end else begin
      strb_q    <= strb_n;
      line_o    <= line_i;
      mask_o    <= mask_i;
      st_data_o <= st_data_i;
    end
  end

  assign ld_o  = strb_q.ld;
  assign st_o  = strb_q.st;
  assign vld_o = strb_q.vld;
endmodule

// File: rtl/plm_resp.sv
module plm_resp #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_i,
  input  logic              ld_issue_n_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              ld_err_i,
  input  logic              st_err_i,
  output logic              busy_o,
  output logic              exc_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              ld_ok_o
);
  logic busy_q;
  logic pend_q;
  logic fall;

  assign fall = busy_q & ~busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      pend_q    <= 1'b0;
      busy_o    <= 1'b0;
      exc_o     <= 1'b0;
      ld_ok_o   <= 1'b0;
      ld_data_o <= '0;
    end else begin
      busy_q <= busy_i;
      busy_o <= busy_i;
      exc_o  <= ld_err_i | st_err_i;
      if (abort_i) begin
        pend_q  <= 1'b0;
        ld_ok_o <= 1'b0;
      end else begin
        // a load issued on this edge survives the retirement of the older one
        pend_q  <= ld_issue_n_i | (pend_q & ~fall);
        ld_ok_o <= fall & pend_q;
        if (fall & pend_q) ld_data_o <= ld_data_i;
      end
    end
  end
endmodule

// File: rtl/port_lsu_adapter.sv
module port_lsu_adapter
  import plm_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF,
  parameter int LANES  = LANES_DEF,
  parameter int LEN_W  = LEN_W_DEF,
  localparam int OFS_W  = $clog2(LANES),
  localparam int LINE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_i,
  input  logic              req_ld_i,
  input  logic              req_st_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_vld_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic              busy_o,
  output logic              addr_exc_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              ld_ok_o,
  output logic [LINE_W-1:0] lsu_addr_o,
  output logic [LANES-1:0]  lsu_mask_o,
  output logic              lsu_ld_o,
  output logic              lsu_st_o,
  output logic [DATA_W-1:0] lsu_st_data_o,
  output logic              lsu_valid_o,
  input  logic              lsu_stall_i,
  input  logic              lsu_busy_i,
  input  logic [DATA_W-1:0] lsu_ld_data_i,
  input  logic              lsu_ld_err_i,
  input  logic              lsu_st_err_i
);
  logic [LANES-1:0] mask_c;
  logic             ld_issue_n;

  plm_mask_expand #(.LANES(LANES), .LEN_W(LEN_W)) i_mask (
    .ofs_i  (addr_i[OFS_W-1:0]),
    .len_i  (len_i),
    .mask_o (mask_c)
  );

  plm_issue #(.LINE_W(LINE_W), .LANES(LANES), .DATA_W(DATA_W)) i_issue (
    .clk          (clk),
    .rst          (rst),
    .abort_i      (abort_i),
    .req_ld_i     (req_ld_i),
    .req_st_i     (req_st_i),
    .addr_vld_i   (addr_vld_i),
    .stall_i      (lsu_stall_i),
    .line_i       (addr_i[ADDR_W-1:OFS_W]),
    .mask_i       (mask_c),
    .st_data_i    (st_data_i),
    .line_o       (lsu_addr_o),
    .mask_o       (lsu_mask_o),
    .st_data_o    (lsu_st_data_o),
    .ld_o         (lsu_ld_o),
    .st_o         (lsu_st_o),
    .vld_o        (lsu_valid_o),
    .ld_issue_n_o (ld_issue_n)
  );

  plm_resp #(.DATA_W(DATA_W)) i_resp (
    .clk          (clk),
    .rst          (rst),
    .abort_i      (abort_i),
    .ld_issue_n_i (ld_issue_n),
    .busy_i       (lsu_busy_i),
    .ld_data_i    (lsu_ld_data_i),
    .ld_err_i     (lsu_ld_err_i),
    .st_err_i     (lsu_st_err_i),
    .busy_o       (busy_o),
    .exc_o        (addr_exc_o),
    .ld_data_o    (ld_data_o),
    .ld_ok_o      (ld_ok_o)
  );
endmodule

// File: rtl/port_lsu_adapter_chk.sv
module port_lsu_adapter_chk (
  input logic clk,
  input logic rst,
  input logic abort_i,
  input logic busy_o,
  input logic addr_exc_o,
  input logic ld_ok_o,
  input logic lsu_ld_o,
  input logic lsu_st_o,
  input logic lsu_valid_o,
  input logic lsu_stall_i,
  input logic lsu_busy_i,
  input logic lsu_ld_err_i,
  input logic lsu_st_err_i
);
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    !(lsu_ld_o && lsu_st_o));

  p_stall_r4: assert property (@(posedge clk) disable iff (rst)
    lsu_stall_i |=> !lsu_valid_o);

  p_exc_r6: assert property (@(posedge clk) disable iff (rst)
    (lsu_ld_err_i || lsu_st_err_i) |=> addr_exc_o);

  p_noexc_r6: assert property (@(posedge clk) disable iff (rst)
    !(lsu_ld_err_i || lsu_st_err_i) |=> !addr_exc_o);

  p_busy_r7: assert property (@(posedge clk) disable iff (rst)
    lsu_busy_i |=> busy_o);

  p_nobusy_r7: assert property (@(posedge clk) disable iff (rst)
    !lsu_busy_i |=> !busy_o);

  p_ldok_fall_r8: assert property (@(posedge clk) disable iff (rst)
    ld_ok_o |-> !$past(lsu_busy_i));

  p_ldok_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    ld_ok_o |=> !ld_ok_o);

  p_abort_r9: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!lsu_ld_o && !lsu_st_o && !lsu_valid_o && !ld_ok_o));
endmodule

bind port_lsu_adapter port_lsu_adapter_chk i_chk (.*);

// File: tb/test_port_lsu_adapter.sv
`timescale 1ns/1ps
module test_port_lsu_adapter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        abort_i = 1'b0;
  logic        req_ld_i = 1'b0;
  logic        req_st_i = 1'b0;
  logic [3:0]  len_i = '0;
  logic [47:0] addr_i = '0;
  logic        addr_vld_i = 1'b0;
  logic [63:0] st_data_i = '0;
  logic        busy_o, addr_exc_o, ld_ok_o;
  logic [63:0] ld_data_o;
  logic [43:0] lsu_addr_o;
  logic [15:0] lsu_mask_o;
  logic        lsu_ld_o, lsu_st_o, lsu_valid_o;
  logic [63:0] lsu_st_data_o;
  logic        lsu_stall_i = 1'b0;
  logic        lsu_busy_i = 1'b0;
  logic [63:0] lsu_ld_data_i = '0;
  logic        lsu_ld_err_i = 1'b0;
  logic        lsu_st_err_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  port_lsu_adapter i_port_lsu_adapter (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_mask(input logic [3:0] ofs, input logic [3:0] len);
    logic [31:0] w;
    w = ((32'd1 << len) - 32'd1) << ofs;
    return w[15:0];
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic drv_req(input logic ld, input logic st, input logic [47:0] a,
                         input logic [3:0] l, input logic v);
    @(negedge clk);
    req_ld_i = ld; req_st_i = st; addr_i = a; len_i = l; addr_vld_i = v;
  endtask

  task automatic idle_clear();
    @(negedge clk);
    req_ld_i = 0; req_st_i = 0; addr_vld_i = 0; lsu_stall_i = 0;
    lsu_busy_i = 0; abort_i = 1;
    tick();
    @(negedge clk);
    abort_i = 0;
    tick();
  endtask

  task automatic t_reset();
    chk("R11 busy_o", busy_o, 0);
    chk("R11 addr_exc_o", addr_exc_o, 0);
    chk("R11 ld_ok_o", ld_ok_o, 0);
    chk("R11 ld_data_o", ld_data_o, 0);
    chk("R11 strobes", {lsu_ld_o, lsu_st_o, lsu_valid_o}, 0);
    chk("R11 lsu_addr_o", lsu_addr_o, 0);
    chk("R11 lsu_mask_o", lsu_mask_o, 0);
    chk("R11 lsu_st_data_o", lsu_st_data_o, 0);
  endtask

  task automatic t_load_issue();
    drv_req(1, 0, 48'h1234_5678_9AB3, 4'd4, 1);
    tick();
    chk("R1 line address", lsu_addr_o, 44'h123_4567_89AB);
    chk("R2 mask ofs3 len4", lsu_mask_o, exp_mask(4'd3, 4'd4));
    chk("R3 load strobe", {lsu_ld_o, lsu_st_o}, 2'b10);
    chk("R4 valid on load", lsu_valid_o, 1);
    idle_clear();
  endtask

  task automatic t_store_issue();
    @(negedge clk); st_data_i = 64'hDEAD_BEEF_0123_4567;
    drv_req(0, 1, 48'hFFFF_0000_1110, 4'd8, 1);
    tick();
    chk("R5 store data", lsu_st_data_o, 64'hDEAD_BEEF_0123_4567);
    chk("R2 mask ofs0 len8", lsu_mask_o, 16'h00FF);
    chk("R3 store strobe", {lsu_ld_o, lsu_st_o}, 2'b01);
    chk("R1 line address store", lsu_addr_o, 44'hFFF_F000_0111);
    idle_clear();
  endtask

  task automatic t_mask_edges();
    drv_req(1, 0, 48'h0000_0000_000E, 4'd5, 1);
    tick();
    chk("R2 mask overflow dropped", lsu_mask_o, 16'hC000);
    drv_req(1, 0, 48'h0000_0000_0007, 4'd0, 1);
    tick();
    chk("R2 mask len0", lsu_mask_o, 16'h0000);
    drv_req(1, 0, 48'h0000_0000_0001, 4'd15, 1);
    tick();
    chk("R2 mask ofs1 len15", lsu_mask_o, 16'hFFFE);
    idle_clear();
  endtask

  task automatic t_both_req();
    drv_req(1, 1, 48'h10, 4'd2, 1);
    tick();
    chk("R3 both requests give no strobe", {lsu_ld_o, lsu_st_o}, 2'b00);
    chk("R4 both requests give no valid", lsu_valid_o, 0);
    idle_clear();
  endtask

  task automatic t_stall();
    drv_req(1, 0, 48'h20, 4'd2, 1);
    lsu_stall_i = 1;
    tick();
    chk("R4 stall masks valid", lsu_valid_o, 0);
    chk("R3 strobe kept under stall", lsu_ld_o, 1);
    @(negedge clk); lsu_stall_i = 0; addr_vld_i = 0;
    tick();
    chk("R4 no addr valid", lsu_valid_o, 0);
    idle_clear();
  endtask

  task automatic t_exc_busy();
    @(negedge clk); lsu_ld_err_i = 1;
    tick();
    chk("R6 load error", addr_exc_o, 1);
    @(negedge clk); lsu_ld_err_i = 0; lsu_st_err_i = 1;
    tick();
    chk("R6 store error", addr_exc_o, 1);
    @(negedge clk); lsu_st_err_i = 0; lsu_busy_i = 1;
    tick();
    chk("R6 no error", addr_exc_o, 0);
    chk("R7 busy high", busy_o, 1);
    @(negedge clk); lsu_busy_i = 0;
    tick();
    chk("R7 busy low", busy_o, 0);
    idle_clear();
  endtask

  task automatic t_load_resp();
    drv_req(1, 0, 48'h40, 4'd8, 1);
    tick();
    @(negedge clk); req_ld_i = 0; addr_vld_i = 0; lsu_busy_i = 1;
    tick();
    chk("R8 no pulse while busy", ld_ok_o, 0);
    @(negedge clk); lsu_busy_i = 0; lsu_ld_data_i = 64'h1111_2222_3333_4444;
    tick();
    chk("R8 pulse on busy fall", ld_ok_o, 1);
    chk("R8 load data", ld_data_o, 64'h1111_2222_3333_4444);
    @(negedge clk); lsu_ld_data_i = 64'h0;
    tick();
    chk("R8 pulse one cycle", ld_ok_o, 0);
    chk("R8 data held", ld_data_o, 64'h1111_2222_3333_4444);
    drv_req(0, 1, 48'h50, 4'd8, 1);
    tick();
    @(negedge clk); req_st_i = 0; addr_vld_i = 0; lsu_busy_i = 1;
    tick();
    @(negedge clk); lsu_busy_i = 0;
    tick();
    chk("R8 no pulse after store", ld_ok_o, 0);
    idle_clear();
  endtask

  task automatic t_abort();
    drv_req(1, 0, 48'h60, 4'd4, 1);
    tick();
    @(negedge clk); abort_i = 1; lsu_busy_i = 1;
    tick();
    chk("R9 abort clears strobes", {lsu_ld_o, lsu_st_o, lsu_valid_o}, 3'b000);
    @(negedge clk); abort_i = 0; req_ld_i = 0; addr_vld_i = 0;
    tick();
    @(negedge clk); lsu_busy_i = 0; lsu_ld_data_i = 64'h5555;
    tick();
    chk("R9 aborted load gives no pulse", ld_ok_o, 0);
    idle_clear();
  endtask

  task automatic t_collide();
    drv_req(1, 0, 48'h70, 4'd8, 1);
    tick();
    @(negedge clk); req_ld_i = 0; addr_vld_i = 0; lsu_busy_i = 1;
    tick();
    @(negedge clk); lsu_busy_i = 0; lsu_ld_data_i = 64'hAAAA_0001;
    req_ld_i = 1; addr_vld_i = 1; addr_i = 48'h80;
    tick();
    chk("R10 old load completes", ld_ok_o, 1);
    chk("R10 old load data", ld_data_o, 64'hAAAA_0001);
    chk("R10 new load issued", {lsu_ld_o, lsu_valid_o}, 2'b11);
    @(negedge clk); req_ld_i = 0; addr_vld_i = 0; lsu_busy_i = 1;
    tick();
    chk("R10 gap between pulses", ld_ok_o, 0);
    @(negedge clk); lsu_busy_i = 0; lsu_ld_data_i = 64'hBBBB_0002;
    tick();
    chk("R10 new load completes", ld_ok_o, 1);
    chk("R10 new load data", ld_data_o, 64'hBBBB_0002);
    idle_clear();
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    t_reset();
    t_load_issue();
    t_store_issue();
    t_mask_edges();
    t_both_req();
    t_stall();
    t_exc_busy();
    t_load_resp();
    t_abort();
    t_collide();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule